// File: doc/BRIEF.md
# Double-Precision Maximum/Minimum Unit

This unit takes two 64-bit IEEE-754 binary64 operands and returns either the larger or the smaller of them, as selected by a one-bit operation input. It works directly on the sign, exponent and fraction fields and needs no general floating-point datapath. The rules are fixed. A NaN on operand A wins over a NaN on operand B. A selected NaN is returned bit for bit, and a signaling NaN is not quieted. Two zeros of any signs give an explicitly signed zero.

Besides the result, the unit reports whether a signaling NaN was the one returned. It also produces a destination write-enable. That write-enable drops when a signaling NaN meets an enabled invalid-operation exception, so the old destination value is kept. The interface is a single-cycle valid handshake. Each accepted operation produces a registered result exactly one cycle later, qualified by the output valid.

Top module: `fp64_maxmin_unit`

## Requirements
- R1: A NaN has an all-ones exponent (bits 62:52) and a nonzero fraction (bits 51:0). If operand A is a NaN, the result is A's exact bit pattern, whatever B holds.
- R2: If A is not a NaN and B is a NaN, the result is B's exact bit pattern, with no quieting.
- R3: A NaN is signaling when fraction bit 51 is 0. `snan_o` is 1 exactly when the returned NaN is signaling. A quiet NaN, or a NaN on B hidden by a NaN on A, does not raise it.
- R4: In max mode with both operands zero, the result is 0x0000000000000000 unless both are negative zero, which gives 0x8000000000000000.
- R5: In min mode with both operands zero, the result is 0x8000000000000000 if either operand is negative zero, and 0x0000000000000000 otherwise.
- R6: `op_i` = 0 selects maximum and `op_i` = 1 selects minimum. For non-NaN operands that are not both zero, max returns A unless A < B, and min returns A only if A < B. In all other cases B is returned, so equal operands give A in max mode and B in min mode.
- R7: The less-than test orders values by sign and magnitude. A negative value lies below any positive value. Between two negatives, the larger magnitude is the smaller value. Infinities are the extremes, and subnormals order by magnitude.
- R8: `wr_en_o` is 0 when `inv_en_i` was 1 and a signaling NaN was detected, and 1 for every other accepted operation.
- R9: `res_o`, `snan_o` and `wr_en_o` are registered and appear one cycle after `valid_i`, together with `valid_o`. When `valid_o` is 0, `snan_o` and `wr_en_o` are 0. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are valid this cycle |
| op_i | input | 1 | 0 = maximum, 1 = minimum |
| inv_en_i | input | 1 | Invalid-operation exception enable |
| a_i | input | 64 | Operand A, binary64 |
| b_i | input | 64 | Operand B, binary64 |
| valid_o | output | 1 | Result valid |
| res_o | output | 64 | Selected value |
| snan_o | output | 1 | Returned NaN was signaling |
| wr_en_o | output | 1 | Destination write enable |

## Verification
On every cycle the assertions check several properties. The one-cycle valid timing must hold, and the result must always be the bit pattern of one of the two operands. A NaN on A, or a lone NaN on B, must come through unchanged. The flag and the write-enable must stay quiet without a valid result, and a signaling NaN with the exception enabled must block the write. The ordering of non-NaN values can only be shown by the bench's vectors. These cover negative pairs, infinities, subnormals, equal operands and every signed-zero combination. The vectors also show whether the quiet/signaling split uses the right fraction bit.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int DATA_W = 1 + EXP_W + FRAC_W;

  typedef enum logic {
    OP_MAX = 1'b0,
    OP_MIN = 1'b1
  } mm_op_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fp_class_t;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W  = fpmm_pkg::EXP_W,
  parameter int FRAC_W = fpmm_pkg::FRAC_W,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input  logic [DATA_W-1:0] val_i,
  output fp_class_t         cls_o
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  assign expo = val_i[DATA_W-2 -: EXP_W];
  assign frac = val_i[FRAC_W-1:0];

  always_comb begin
    cls_o.sign    = val_i[DATA_W-1];
    cls_o.is_nan  = (&expo) && (|frac);
    // quiet bit is the fraction MSB
    cls_o.is_snan = (&expo) && (|frac) && !frac[FRAC_W-1];
    cls_o.is_zero = (expo == '0) && (frac == '0);
  end
endmodule

// File: rtl/fpmm_less.sv
module fpmm_less #(
  parameter int DATA_W = fpmm_pkg::DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              lt_o
);
  logic [DATA_W-2:0] a_mag, b_mag;
  logic              both_zero;

  assign a_mag     = a_i[DATA_W-2:0];
  assign b_mag     = b_i[DATA_W-2:0];
  assign both_zero = (a_mag == '0) && (b_mag == '0);

  // sign-magnitude ordering; callers exclude NaNs
  always_comb begin
    unique case ({a_i[DATA_W-1], b_i[DATA_W-1]})
      2'b00:   lt_o = a_mag < b_mag;
      2'b11:   lt_o = a_mag > b_mag;
      2'b10:   lt_o = !both_zero;
      default: lt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
  import fpmm_pkg::*;
#(
  parameter int DATA_W = fpmm_pkg::DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  fp_class_t         a_cls_i,
  input  fp_class_t         b_cls_i,
  input  logic              lt_i,
  input  mm_op_e            op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              snan_o
);
  localparam logic [DATA_W-1:0] POS_ZERO = '0;
  localparam logic [DATA_W-1:0] NEG_ZERO = {1'b1, {(DATA_W-1){1'b0}}};

  logic zero_neg;

  always_comb begin
    zero_neg = (op_i == OP_MAX) ? (a_cls_i.sign && b_cls_i.sign)
                                : (a_cls_i.sign || b_cls_i.sign);
    snan_o = 1'b0;
    if (a_cls_i.is_nan) begin
      res_o  = a_i;
      snan_o = a_cls_i.is_snan;
    end else if (b_cls_i.is_nan) begin
      res_o  = b_i;
      snan_o = b_cls_i.is_snan;
    end else if (a_cls_i.is_zero && b_cls_i.is_zero) begin
      res_o = zero_neg ? NEG_ZERO : POS_ZERO;
    end else if (op_i == OP_MAX) begin
      res_o = lt_i ? b_i : a_i;
    end else begin
      res_o = lt_i ? a_i : b_i;
    end
  end
endmodule

// File: rtl/fp64_maxmin_unit.sv
module fp64_maxmin_unit
  import fpmm_pkg::*;
#(
  parameter int EXP_W  = fpmm_pkg::EXP_W,
  parameter int FRAC_W = fpmm_pkg::FRAC_W,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic              inv_en_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              snan_o,
  output logic              wr_en_o
);
  localparam int NUM_OPND = 2;

  logic [NUM_OPND-1:0][DATA_W-1:0] opnd;
  fp_class_t                       cls [NUM_OPND];
  logic                            lt;
  logic [DATA_W-1:0]               res_d;
  logic                            snan_d;

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_cls
    fpmm_classify #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) u_cls (
      .val_i(opnd[gi]),
      .cls_o(cls[gi])
    );
  end

  fpmm_less #(.DATA_W(DATA_W)) u_less (
    .a_i (a_i),
    .b_i (b_i),
    .lt_o(lt)
  );

  fpmm_select #(.DATA_W(DATA_W)) u_sel (
    .a_i    (a_i),
    .b_i    (b_i),
    .a_cls_i(cls[0]),
    .b_cls_i(cls[1]),
    .lt_i   (lt),
    .op_i   (mm_op_e'(op_i)),
    .res_o  (res_d),
    .snan_o (snan_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      snan_o  <= 1'b0;
      wr_en_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      snan_o  <= valid_i && snan_d;
      wr_en_o <= valid_i && !(snan_d && inv_en_i);
      if (valid_i) res_o <= res_d;
    end
  end
endmodule

// File: rtl/fpmm_chk.sv
module fpmm_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              inv_en_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] res_o,
  input logic              snan_o,
  input logic              wr_en_o
);
  logic a_nan, b_nan;
  assign a_nan = (&a_i[DATA_W-2 -: EXP_W]) && (|a_i[FRAC_W-1:0]);
  assign b_nan = (&b_i[DATA_W-2 -: EXP_W]) && (|b_i[FRAC_W-1:0]);

  // R9
  valid_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!snan_o && !wr_en_o));
  // R1
  a_nan_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_nan) |=> (res_o == $past(a_i)));
  // R2
  b_nan_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !a_nan && b_nan) |=> (res_o == $past(b_i)));
  // R6
  res_is_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (res_o == $past(a_i) || res_o == $past(b_i)));
  // R8
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && inv_en_i) |=> (wr_en_o == !snan_o));
  // R3
  no_nan_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !a_nan && !b_nan) |=> !snan_o);
endmodule

bind fp64_maxmin_unit fpmm_chk #(
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .inv_en_i(inv_en_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .valid_o (valid_o),
  .res_o   (res_o),
  .snan_o  (snan_o),
  .wr_en_o (wr_en_o)
);

// File: tb/fp64_maxmin_unit_tb_top.sv
module fp64_maxmin_unit_tb_top;
  localparam logic [63:0] P0 = 64'h0000000000000000, N0 = 64'h8000000000000000;
  localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000;
  localparam logic [63:0] N1 = 64'hBFF0000000000000, N2 = 64'hC000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000, NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QN1 = 64'h7FF8000000000001, QN2 = 64'hFFF8000000000ABC;
  localparam logic [63:0] SN1 = 64'h7FF0000000000001, SN2 = 64'hFFF4000000000000;
  localparam logic [63:0] DN1 = 64'h0000000000000001, DN2 = 64'h000FFFFFFFFFFFFF;

  typedef struct packed {
    logic        op;
    logic        inv;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic        snan;
    logic        we;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, P1,   P2,   P2,   1'b0, 1'b1},  // R6 max
    '{1'b1, 1'b0, P1,   P2,   P1,   1'b0, 1'b1},  // R6 min
    '{1'b0, 1'b0, P1,   P1,   P1,   1'b0, 1'b1},  // R6 equal
    '{1'b0, 1'b0, N1,   N2,   N1,   1'b0, 1'b1},  // R7 negatives
    '{1'b1, 1'b0, N1,   N2,   N2,   1'b0, 1'b1},  // R7
    '{1'b0, 1'b0, NINF, N2,   N2,   1'b0, 1'b1},  // R7 infinity
    '{1'b1, 1'b0, PINF, P1,   P1,   1'b0, 1'b1},  // R7
    '{1'b0, 1'b0, P2,   N1,   P2,   1'b0, 1'b1},  // R7 signs
    '{1'b1, 1'b0, DN1,  DN2,  DN1,  1'b0, 1'b1},  // R7 subnormal
    '{1'b0, 1'b0, DN1,  P0,   DN1,  1'b0, 1'b1},  // R7
    '{1'b0, 1'b0, QN1,  SN1,  QN1,  1'b0, 1'b1},  // R1 quiet on A hides B
    '{1'b1, 1'b1, SN1,  QN1,  SN1,  1'b1, 1'b0},  // R1 R3 R8
    '{1'b0, 1'b0, P1,   SN2,  SN2,  1'b1, 1'b1},  // R2 R3 no enable
    '{1'b1, 1'b0, N1,   QN2,  QN2,  1'b0, 1'b1},  // R2
    '{1'b0, 1'b1, QN1,  P1,   QN1,  1'b0, 1'b1},  // R8 quiet not blocked
    '{1'b1, 1'b1, P2,   SN1,  SN1,  1'b1, 1'b0},  // R8
    '{1'b0, 1'b0, P0,   N0,   P0,   1'b0, 1'b1},  // R4
    '{1'b0, 1'b0, N0,   N0,   N0,   1'b0, 1'b1},  // R4
    '{1'b0, 1'b0, N0,   P0,   P0,   1'b0, 1'b1},  // R4
    '{1'b1, 1'b0, P0,   N0,   N0,   1'b0, 1'b1},  // R5
    '{1'b1, 1'b0, P0,   P0,   P0,   1'b0, 1'b1},  // R5
    '{1'b1, 1'b0, N0,   P0,   N0,   1'b0, 1'b1},  // R5
    '{1'b1, 1'b0, N0,   P1,   N0,   1'b0, 1'b1},  // R6 zero with nonzero
    '{1'b0, 1'b0, N1,   N0,   N0,   1'b0, 1'b1}   // R7
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, op_i = 1'b0, inv_en_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic valid_o, snan_o, wr_en_o;
  logic [63:0] res_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  fp64_maxmin_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .inv_en_i(inv_en_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o),
    .res_o(res_o), .snan_o(snan_o), .wr_en_o(wr_en_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic op, logic inv, logic [63:0] a, logic [63:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; inv_en_i = inv; a_i = a; b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 reset valid", 64'(valid_o), 64'd0);
    chk("R9 reset res", res_o, 64'd0);
    chk("R9 reset flags", 64'({snan_o, wr_en_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 idle valid", 64'(valid_o), 64'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].inv, VECS[i].a, VECS[i].b);
      chk($sformatf("vec%0d valid R9", i), 64'(valid_o), 64'd1);
      chk($sformatf("vec%0d res", i), res_o, VECS[i].res);
      chk($sformatf("vec%0d snan R3", i), 64'(snan_o), 64'(VECS[i].snan));
      chk($sformatf("vec%0d wr_en R8", i), 64'(wr_en_o), 64'(VECS[i].we));
    end

    // R9 bubble: flags drop, result held
    @(negedge clk_i);
    chk("R9 bubble valid", 64'(valid_o), 64'd0);
    chk("R9 bubble flags", 64'({snan_o, wr_en_o}), 64'd0);
    chk("R9 bubble hold", res_o, VECS[NV-1].res);

    // R9 back-to-back
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 1'b0; inv_en_i = 1'b1; a_i = SN2; b_i = P1;
    @(negedge clk_i);
    chk("R9 b2b first", res_o, SN2);
    chk("R8 b2b first wr", 64'(wr_en_o), 64'd0);
    op_i = 1'b1; a_i = N2; b_i = PINF;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R9 b2b second", res_o, N2);
    chk("R8 b2b second wr", 64'(wr_en_o), 64'd1);
    chk("R3 b2b second snan", 64'(snan_o), 64'd0);

    // R9 async reset clears outputs
    rst_ni = 1'b0;
    #1;
    chk("R9 async reset", res_o, 64'd0);
    rst_ni = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule